// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block collects the event pulses of a multi-channel display fetch engine and a few controller-wide events into two sticky status words, weighs them against software masks and drives a single level-sensitive interrupt line. Channel 0 and the controller-wide events share the first status word. Channels 1 and up report into the second word, where each event kind takes its own byte-aligned group of bits.

When a channel raises an unmasked start-of-frame, end-of-frame, branch or bus-error event and the interrupt line is still low, the block records that channel's frame identifier so software can see which frame caused the interrupt. If the line is already high, the identifier is left alone and a "subsequent interrupt" flag is set instead. Software clears status bits by writing ones. A few bits are deliberately left outside the clear masks. The register bus decode and the event sources are outside the block. It sees only pulses, per-channel command enables, frame identifiers, the two mask words and clear strobes.

Top module: `disp_irq_status`

## Requirements
- R1: After synchronous reset `stat0`, `stat1`, `src_id` and `irq` are all zero.
- R2: Channel 0 start-of-frame sets `stat0` bit 1 and end-of-frame sets bit 8, each only when that channel's command enable (`sof_ena`/`eof_ena`) is high. Its branch pulse sets bit 9 with no enable, and its input underrun sets bit 4. Status changes are visible one clock after the pulse.
- R3: For a channel k from 1 to NCH-1, start-of-frame sets `stat1` bit k-1 and end-of-frame sets bit k+7, both gated by the command enables. Branch sets bit k+15. Input underrun sets `stat0` bit 5 for k=1 and `stat1` bit k+23 for k of 2 or more.
- R4: Controller-wide pulses set `stat0` bits as follows: last frame done sets bit 0, AC-bias count sets bit 3, output underrun sets bit 6, read status sets bit 11 and command interrupt sets bit 12. A 1-to-0 transition of `en_lvl` between two clocks sets bit 7.
- R5: A bus-error pulse on any channel sets `stat0` bit 2 and loads the channel number into `stat0[30:28]`, whatever the masks say. When several channels err in one cycle, the lowest number is stored.
- R6: `irq` is high exactly when some `stat1` bit has its `mask1` bit at 0, or some `stat0` bit among 0,1,4,6,7,8,9,11,12 has its `mask0` bit at the same position at 0, or `stat0` bit 5 is set while `mask1` bit 24 is 0. `stat0` bits 2, 3 and 10 never drive `irq`.
- R7: An unmasked start-of-frame, end-of-frame or branch event, or any bus error, while `irq` is low loads `src_id` on the next clock with the frame identifier of the lowest-numbered channel with such an event. Masked events leave `src_id` unchanged.
- R8: Such an event while `irq` is already high sets `stat0` bit 10 and leaves `src_id` unchanged.
- R9: A `clr0_we` write clears the `stat0` bits among 11:0 whose `clr_data` bit is 1. Bit 12 is not cleared. Writing bit 2 also zeroes `stat0[30:28]`.
- R10: A `clr1_we` write clears only those `stat1` bits that are set in both `clr_data` and 0x003E3F3F.
- R11: When an event and a clearing write hit the same bit in one cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_lvl | input | 1 | Controller enable level, watched for a falling transition |
| sof_pulse | input | NCH | Per-channel start-of-frame pulses |
| eof_pulse | input | NCH | Per-channel end-of-frame pulses |
| brs_pulse | input | NCH | Per-channel branch-taken pulses |
| ber_pulse | input | NCH | Per-channel bus-error pulses |
| iu_pulse | input | NCH | Per-channel input-underrun pulses |
| sof_ena | input | NCH | Current command word enables start-of-frame reporting |
| eof_ena | input | NCH | Current command word enables end-of-frame reporting |
| frame_ids | input | NCH*ID_W | Frame identifier of each channel, channel 0 in the low slice |
| done_pulse | input | 1 | Last frame done |
| acb_pulse | input | 1 | AC-bias count reached |
| outrun_pulse | input | 1 | Output underrun |
| rdstat_pulse | input | 1 | Panel read status ready |
| cmdint_pulse | input | 1 | Command interrupt |
| mask0 | input | 13 | Masks for `stat0` bits, same positions, 1 = masked |
| mask1 | input | 32 | Masks for `stat1` bits, same positions, 1 = masked |
| clr0_we | input | 1 | Write-one-to-clear strobe for `stat0` |
| clr1_we | input | 1 | Write-one-to-clear strobe for `stat1` |
| clr_data | input | 32 | Clear data for either strobe |
| stat0 | output | 32 | Status word 0 |
| stat1 | output | 32 | Status word 1 |
| src_id | output | ID_W | Captured frame identifier |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is several channels raising unmasked events in the same cycle while the interrupt line is in a chosen state. The capture-or-flag decision and the lowest-channel choice of both the identifier and the error channel depend on that. Directed sequences first build up masked status, then unmask one bit to raise the line, and then fire events that collide with clearing writes. A long phase of sparse random pulses follows, with masks, clears and the enable level reshuffled often, so that simultaneous multi-channel events occur with the line both high and low. Every cycle is compared against a reference computed in the bench.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

    // status word 0 bit positions
    localparam int B_DONE   = 0;
    localparam int B_SOF0   = 1;
    localparam int B_BERR   = 2;
    localparam int B_ACB    = 3;
    localparam int B_IU0    = 4;
    localparam int B_IU1    = 5;
    localparam int B_OUTRUN = 6;
    localparam int B_QDIS   = 7;
    localparam int B_EOF0   = 8;
    localparam int B_BRS0   = 9;
    localparam int B_SUB    = 10;
    localparam int B_RDST   = 11;
    localparam int B_CMDI   = 12;

    localparam int S0_LOW_W = 13;
    localparam int BCH_LO   = 28;
    localparam int BCH_W    = 3;

    // group offsets inside status word 1 (channel k >= 1)
    localparam int G1_SOF = -1;
    localparam int G1_EOF = 7;
    localparam int G1_BRS = 15;
    localparam int G1_IU  = 23;

    // mask1 bit that also masks the channel-1 underrun in status word 0
    localparam int M1_IU_CH1 = 1 + G1_IU;

    localparam logic [S0_LOW_W-1:0] S0_CLR_MASK = 13'h0FFF;
    localparam logic [S0_LOW_W-1:0] S0_IRQ_SRC  = 13'h1BF3;
    localparam logic [31:0]         S1_CLR_MASK = 32'h003E_3F3F;

    typedef struct packed {
        logic sof;
        logic eof;
        logic brs;
        logic ber;
        logic iu;
    } chan_evt_t;

    typedef struct packed {
        logic done;
        logic acb;
        logic outrun;
        logic rdst;
        logic cmdi;
    } glob_evt_t;

    function automatic logic [S0_LOW_W-1:0] glob_to_bits(glob_evt_t g);
        logic [S0_LOW_W-1:0] v;
        v = '0;
        v[B_DONE]   = g.done;
        v[B_ACB]    = g.acb;
        v[B_OUTRUN] = g.outrun;
        v[B_RDST]   = g.rdst;
        v[B_CMDI]   = g.cmdi;
        return v;
    endfunction

endpackage

// File: rtl/disp_irq_chan.sv
module disp_irq_chan
    import disp_irq_pkg::*;
#(
    parameter int CH = 0
) (
    input  chan_evt_t           evt,
    input  logic                sof_ena,
    input  logic                eof_ena,
    input  logic                m_sof,
    input  logic                m_eof,
    input  logic                m_brs,
    output logic [S0_LOW_W-1:0] set0,
    output logic [31:0]         set1,
    output logic                hit
);
    logic sof_v, eof_v;

    assign sof_v = evt.sof & sof_ena;
    assign eof_v = evt.eof & eof_ena;

    generate
        if (CH == 0) begin : g_ch0
            always_comb begin
                set0         = '0;
                set0[B_SOF0] = sof_v;
                set0[B_EOF0] = eof_v;
                set0[B_BRS0] = evt.brs;
                set0[B_IU0]  = evt.iu;
                set1         = '0;
            end
        end else begin : g_chn
            localparam int P_SOF = CH + G1_SOF;
            localparam int P_EOF = CH + G1_EOF;
            localparam int P_BRS = CH + G1_BRS;
            localparam int P_IU  = CH + G1_IU;
            always_comb begin
                set0        = '0;
                set1        = '0;
                set1[P_SOF] = sof_v;
                set1[P_EOF] = eof_v;
                set1[P_BRS] = evt.brs;
                if (CH == 1) set0[B_IU1] = evt.iu;
                else         set1[P_IU]  = evt.iu;
            end
        end
    endgenerate

    // identifier-eligible event: unmasked frame/branch event or any bus error
    assign hit = (sof_v & ~m_sof) | (eof_v & ~m_eof) | (evt.brs & ~m_brs) | evt.ber;

endmodule

// File: rtl/disp_irq_capture.sv
module disp_irq_capture
    import disp_irq_pkg::*;
#(
    parameter int NCH  = 7,
    parameter int ID_W = 16,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NCH-1:0]      hit_v,
    input  logic [NCH-1:0]      ber_v,
    input  logic [NCH*ID_W-1:0] frame_ids,
    input  logic                irq_now,
    output logic [ID_W-1:0]     src_id,
    output logic                any_hit,
    output logic                sub_set,
    output logic                ber_any,
    output logic [BCH_W-1:0]    ber_ch
);
    logic [CH_W-1:0] first_h, first_b;
    logic [ID_W-1:0] sel_id;

    // lowest channel wins for both the identifier and the error channel
    always_comb begin
        any_hit = 1'b0;
        first_h = '0;
        ber_any = 1'b0;
        first_b = '0;
        for (int i = 0; i < NCH; i++) begin
            if (hit_v[i] && !any_hit) begin
                any_hit = 1'b1;
                first_h = CH_W'(i);
            end
            if (ber_v[i] && !ber_any) begin
                ber_any = 1'b1;
                first_b = CH_W'(i);
            end
        end
    end

    assign sel_id  = frame_ids[first_h*ID_W +: ID_W];
    assign ber_ch  = BCH_W'(first_b);
    assign sub_set = any_hit & irq_now;

    always_ff @(posedge clk) begin
        if (rst)                    src_id <= '0;
        else if (any_hit && !irq_now) src_id <= sel_id;
    end

    p_id_load_r7: assert property (@(posedge clk) disable iff (rst)
        (any_hit && !irq_now) |=> (src_id == $past(sel_id)));

    p_id_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(any_hit && !irq_now) |=> $stable(src_id));

endmodule

// File: rtl/disp_irq_bank.sv
module disp_irq_bank
    import disp_irq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en_lvl,
    input  logic [S0_LOW_W-1:0] set0,
    input  logic [31:0]         set1,
    input  glob_evt_t           glob,
    input  logic                ber_any,
    input  logic [BCH_W-1:0]    ber_ch,
    input  logic                sub_set,
    input  logic [S0_LOW_W-1:0] mask0,
    input  logic [31:0]         mask1,
    input  logic                clr0_we,
    input  logic                clr1_we,
    input  logic [31:0]         clr_data,
    output logic [31:0]         stat0,
    output logic [31:0]         stat1,
    output logic                irq
);
    logic [S0_LOW_W-1:0] s0_low, s0_nx, set_all, clr0, eff_mask;
    logic [BCH_W-1:0]    bch, bch_nx;
    logic [31:0]         s1, s1_nx, clr1;
    logic                en_q;

    always_comb begin
        set_all          = set0 | glob_to_bits(glob);
        set_all[B_QDIS]  = set_all[B_QDIS] | (en_q & ~en_lvl);
        set_all[B_BERR]  = set_all[B_BERR] | ber_any;
        set_all[B_SUB]   = set_all[B_SUB]  | sub_set;
        clr0  = clr0_we ? (clr_data[S0_LOW_W-1:0] & S0_CLR_MASK) : '0;
        clr1  = clr1_we ? (clr_data & S1_CLR_MASK) : '0;
        // set is applied after clear, so a collision leaves the bit set
        s0_nx = (s0_low & ~clr0) | set_all;
        s1_nx = (s1 & ~clr1) | set1;
        if (ber_any)                          bch_nx = ber_ch;
        else if (clr0_we && clr_data[B_BERR]) bch_nx = '0;
        else                                  bch_nx = bch;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_low <= '0;
            s1     <= '0;
            bch    <= '0;
            en_q   <= 1'b0;
        end else begin
            s0_low <= s0_nx;
            s1     <= s1_nx;
            bch    <= bch_nx;
            en_q   <= en_lvl;
        end
    end

    assign stat0 = {1'b0, bch, {(BCH_LO-S0_LOW_W){1'b0}}, s0_low};
    assign stat1 = s1;

    always_comb begin
        eff_mask            = mask0;
        eff_mask[B_IU1]     = mask1[M1_IU_CH1];
        irq = (|(s0_low & S0_IRQ_SRC & ~eff_mask)) | (|(s1 & ~mask1));
    end

    p_qdis_r4: assert property (@(posedge clk) disable iff (rst)
        (en_q && !en_lvl) |=> stat0[B_QDIS]);

    p_ber_field_r5: assert property (@(posedge clk) disable iff (rst)
        ber_any |=> (stat0[B_BERR] && stat0[BCH_LO +: BCH_W] == $past(ber_ch)));

    p_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (stat1 == 32'd0 && (stat0[S0_LOW_W-1:0] & S0_IRQ_SRC) == '0) |-> !irq);

    p_cmdi_kept_r9: assert property (@(posedge clk) disable iff (rst)
        stat0[B_CMDI] |=> stat0[B_CMDI]);

    p_s1_fixed_r10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat1 & ~S1_CLR_MASK & $past(stat1)) == ($past(stat1) & ~S1_CLR_MASK)));

    p_set_wins_r11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat1 & $past(set1)) == $past(set1)));

endmodule

// File: rtl/disp_irq_status.sv
module disp_irq_status
    import disp_irq_pkg::*;
#(
    parameter int NCH  = 7,
    parameter int ID_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_lvl,
    input  logic [NCH-1:0]      sof_pulse,
    input  logic [NCH-1:0]      eof_pulse,
    input  logic [NCH-1:0]      brs_pulse,
    input  logic [NCH-1:0]      ber_pulse,
    input  logic [NCH-1:0]      iu_pulse,
    input  logic [NCH-1:0]      sof_ena,
    input  logic [NCH-1:0]      eof_ena,
    input  logic [NCH*ID_W-1:0] frame_ids,
    input  logic                done_pulse,
    input  logic                acb_pulse,
    input  logic                outrun_pulse,
    input  logic                rdstat_pulse,
    input  logic                cmdint_pulse,
    input  logic [12:0]         mask0,
    input  logic [31:0]         mask1,
    input  logic                clr0_we,
    input  logic                clr1_we,
    input  logic [31:0]         clr_data,
    output logic [31:0]         stat0,
    output logic [31:0]         stat1,
    output logic [ID_W-1:0]     src_id,
    output logic                irq
);
    logic [S0_LOW_W-1:0] set0_v [NCH];
    logic [31:0]         set1_v [NCH];
    logic [NCH-1:0]      hit_v;
    logic [S0_LOW_W-1:0] set0_all;
    logic [31:0]         set1_all;
    logic                any_hit, sub_set, ber_any;
    logic [BCH_W-1:0]    ber_ch;
    glob_evt_t           glob;

    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            chan_evt_t ev;
            logic      m_sof, m_eof, m_brs;
            assign ev = '{sof: sof_pulse[c], eof: eof_pulse[c], brs: brs_pulse[c],
                          ber: ber_pulse[c], iu: iu_pulse[c]};
            if (c == 0) begin : g_m0
                assign m_sof = mask0[B_SOF0];
                assign m_eof = mask0[B_EOF0];
                assign m_brs = mask0[B_BRS0];
            end else begin : g_mn
                assign m_sof = mask1[c + G1_SOF];
                assign m_eof = mask1[c + G1_EOF];
                assign m_brs = mask1[c + G1_BRS];
            end
            disp_irq_chan #(.CH(c)) u_chan (
                .evt     (ev),
                .sof_ena (sof_ena[c]),
                .eof_ena (eof_ena[c]),
                .m_sof   (m_sof),
                .m_eof   (m_eof),
                .m_brs   (m_brs),
                .set0    (set0_v[c]),
                .set1    (set1_v[c]),
                .hit     (hit_v[c])
            );
        end
    endgenerate

    always_comb begin
        set0_all = '0;
        set1_all = '0;
        for (int i = 0; i < NCH; i++) begin
            set0_all = set0_all | set0_v[i];
            set1_all = set1_all | set1_v[i];
        end
    end

    assign glob = '{done: done_pulse, acb: acb_pulse, outrun: outrun_pulse,
                    rdst: rdstat_pulse, cmdi: cmdint_pulse};

    disp_irq_capture #(.NCH(NCH), .ID_W(ID_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .hit_v     (hit_v),
        .ber_v     (ber_pulse),
        .frame_ids (frame_ids),
        .irq_now   (irq),
        .src_id    (src_id),
        .any_hit   (any_hit),
        .sub_set   (sub_set),
        .ber_any   (ber_any),
        .ber_ch    (ber_ch)
    );

    disp_irq_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .en_lvl   (en_lvl),
        .set0     (set0_all),
        .set1     (set1_all),
        .glob     (glob),
        .ber_any  (ber_any),
        .ber_ch   (ber_ch),
        .sub_set  (sub_set),
        .mask0    (mask0),
        .mask1    (mask1),
        .clr0_we  (clr0_we),
        .clr1_we  (clr1_we),
        .clr_data (clr_data),
        .stat0    (stat0),
        .stat1    (stat1),
        .irq      (irq)
    );

    p_sub_r8: assert property (@(posedge clk) disable iff (rst)
        (any_hit && irq) |=> stat0[B_SUB]);

    p_sof0_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (!stat0[B_SOF0] && !(sof_pulse[0] && sof_ena[0])) |=> !stat0[B_SOF0]);

endmodule

// File: tb/tb_disp_irq_status.sv
module tb_disp_irq_status;
    localparam int NCH  = 7;
    localparam int ID_W = 16;

    logic                clk = 1'b0;
    logic                rst;
    logic                en_lvl;
    logic [NCH-1:0]      sof_p, eof_p, brs_p, ber_p, iu_p, sof_en, eof_en;
    logic [NCH*ID_W-1:0] fids;
    logic                done_p, acb_p, outrun_p, rdst_p, cmdi_p;
    logic [12:0]         mask0;
    logic [31:0]         mask1;
    logic                clr0_we, clr1_we;
    logic [31:0]         clr_data;
    logic [31:0]         stat0, stat1;
    logic [ID_W-1:0]     src_id;
    logic                irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done_flag = 0;

    logic [31:0]     m_s0, m_s1;
    logic [ID_W-1:0] m_id;
    logic            m_en_q;

    always #4 clk = ~clk;

    disp_irq_status #(.NCH(NCH), .ID_W(ID_W)) dut (
        .clk(clk), .rst(rst), .en_lvl(en_lvl),
        .sof_pulse(sof_p), .eof_pulse(eof_p), .brs_pulse(brs_p),
        .ber_pulse(ber_p), .iu_pulse(iu_p), .sof_ena(sof_en), .eof_ena(eof_en),
        .frame_ids(fids), .done_pulse(done_p), .acb_pulse(acb_p),
        .outrun_pulse(outrun_p), .rdstat_pulse(rdst_p), .cmdint_pulse(cmdi_p),
        .mask0(mask0), .mask1(mask1), .clr0_we(clr0_we), .clr1_we(clr1_we),
        .clr_data(clr_data), .stat0(stat0), .stat1(stat1), .src_id(src_id), .irq(irq)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [ID_W-1:0] fid(input int c);
        return fids[c*ID_W +: ID_W];
    endfunction

    // reference interrupt level from R6
    function automatic logic model_irq();
        logic [12:0] eff;
        eff = mask0;
        eff[5] = mask1[24];
        return (|(m_s0[12:0] & 13'h1BF3 & ~eff)) | (|(m_s1 & ~mask1));
    endfunction

    task automatic model_next(output logic [31:0] n0, output logic [31:0] n1, output logic [ID_W-1:0] nid);
        logic [12:0] s0set, clr0;
        logic [31:0] s1set, clr1;
        logic [2:0]  fld;
        logic        irqn, anyb;
        int          firsth, firstb;
        irqn = model_irq();
        s0set = '0; s1set = '0; firsth = -1; anyb = 1'b0; firstb = 0;
        for (int c = 0; c < NCH; c++) begin
            logic sv, ev, h;
            sv = sof_p[c] & sof_en[c];
            ev = eof_p[c] & eof_en[c];
            if (c == 0) begin
                s0set[1] = s0set[1] | sv;  s0set[8] = s0set[8] | ev;
                s0set[9] = s0set[9] | brs_p[c]; s0set[4] = s0set[4] | iu_p[c];
                h = (sv & ~mask0[1]) | (ev & ~mask0[8]) | (brs_p[c] & ~mask0[9]);
            end else begin
                s1set[c-1]  = s1set[c-1]  | sv;
                s1set[c+7]  = s1set[c+7]  | ev;
                s1set[c+15] = s1set[c+15] | brs_p[c];
                if (c == 1) s0set[5] = s0set[5] | iu_p[c];
                else        s1set[c+23] = s1set[c+23] | iu_p[c];
                h = (sv & ~mask1[c-1]) | (ev & ~mask1[c+7]) | (brs_p[c] & ~mask1[c+15]);
            end
            h = h | ber_p[c];
            if (h && firsth < 0) firsth = c;
            if (ber_p[c] && !anyb) begin anyb = 1'b1; firstb = c; end
        end
        s0set[0]  = s0set[0]  | done_p;
        s0set[3]  = s0set[3]  | acb_p;
        s0set[6]  = s0set[6]  | outrun_p;
        s0set[11] = s0set[11] | rdst_p;
        s0set[12] = s0set[12] | cmdi_p;
        s0set[7]  = s0set[7]  | (m_en_q & ~en_lvl);
        s0set[2]  = s0set[2]  | anyb;
        s0set[10] = s0set[10] | ((firsth >= 0) & irqn);
        clr0 = clr0_we ? {1'b0, clr_data[11:0]} : 13'd0;
        clr1 = clr1_we ? (clr_data & 32'h003E3F3F) : 32'd0;
        fld  = m_s0[30:28];
        if (anyb)                        fld = 3'(firstb);
        else if (clr0_we && clr_data[2]) fld = 3'd0;
        n0 = {1'b0, fld, 15'd0, (m_s0[12:0] & ~clr0) | s0set};
        n1 = (m_s1 & ~clr1) | s1set;
        nid = (firsth >= 0 && !irqn) ? fid(firsth) : m_id;
    endtask

    task automatic idle();
        sof_p = '0; eof_p = '0; brs_p = '0; ber_p = '0; iu_p = '0;
        done_p = 0; acb_p = 0; outrun_p = 0; rdst_p = 0; cmdi_p = 0;
        clr0_we = 0; clr1_we = 0; clr_data = '0;
    endtask

    // one clock: predict, step, compare every output
    task automatic tick(input string tag);
        logic [31:0] n0, n1;
        logic [ID_W-1:0] nid;
        model_next(n0, n1, nid);
        @(posedge clk); #2;
        m_s0 = n0; m_s1 = n1; m_id = nid; m_en_q = en_lvl;
        chk(tag, "stat0", stat0, m_s0);
        chk(tag, "stat1", stat1, m_s1);
        chk(tag, "src_id", 32'(src_id), 32'(m_id));
        chk(tag, "irq", 32'(irq), 32'(model_irq()));
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1'b1; en_lvl = 1'b0;
        @(posedge clk); @(posedge clk); #2;
        rst = 1'b0;
        m_s0 = '0; m_s1 = '0; m_id = '0; m_en_q = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        sof_en = '0; eof_en = '0;
        mask0 = 13'h1FFF; mask1 = 32'hFFFF_FFFF;
        for (int c = 0; c < NCH; c++) fids[c*ID_W +: ID_W] = ID_W'(16'hA000 + c * 16'h0111);
        do_reset();

        // R1 reset state
        chk("R1", "stat0", stat0, 32'd0);
        chk("R1", "stat1", stat1, 32'd0);
        chk("R1", "src_id", 32'(src_id), 32'd0);
        chk("R1", "irq", 32'(irq), 32'd0);

        // R2 channel 0, all masked
        sof_p[0] = 1'b1; tick("R2");
        chk("R2", "sof gated off", stat0, 32'd0);
        sof_en[0] = 1'b1; sof_p[0] = 1'b1; tick("R2");
        chk("R2", "sof bit1", stat0, 32'h2);
        eof_en[0] = 1'b1; eof_p[0] = 1'b1; brs_p[0] = 1'b1; tick("R2");
        chk("R2", "eof/branch", stat0, 32'h302);

        // R3 higher channels
        sof_en[3] = 1'b1; eof_en[3] = 1'b1;
        sof_p[3] = 1'b1; eof_p[3] = 1'b1; brs_p[3] = 1'b1; brs_p[1] = 1'b1; tick("R3");
        chk("R3", "ch3/ch1 groups", stat1, 32'h0005_0404);
        iu_p[0] = 1'b1; iu_p[1] = 1'b1; iu_p[4] = 1'b1; tick("R3");
        chk("R3", "underrun s0", stat0, 32'h332);
        chk("R3", "underrun s1", stat1, 32'h0805_0404);

        // R4 controller-wide events and enable fall
        done_p = 1; acb_p = 1; outrun_p = 1; rdst_p = 1; cmdi_p = 1; tick("R4");
        chk("R4", "globals", stat0, 32'h1B7B);
        en_lvl = 1'b1; tick("R4");
        en_lvl = 1'b0; tick("R4");
        chk("R4", "quick disable", stat0, 32'h1BFB);
        chk("R7", "masked keeps id", 32'(src_id), 32'd0);

        // R5 / R7 bus error on ch5 and ch2, unmaskable
        ber_p[5] = 1'b1; ber_p[2] = 1'b1; tick("R5");
        chk("R5", "ber field", stat0, 32'h2000_1BFF);
        chk("R7", "id from ch2", 32'(src_id), 32'(fid(2)));
        chk("R6", "ber no irq", 32'(irq), 32'd0);

        // R9 clear word 0
        clr0_we = 1'b1; clr_data = 32'hFFFF_FFFF; tick("R9");
        chk("R9", "clear s0", stat0, 32'h1000);

        // R10 clear word 1
        clr1_we = 1'b1; clr_data = 32'hFFFF_FFFF; tick("R10");
        chk("R10", "clear s1", stat1, 32'h0801_0000);

        // R6 mask windows
        mask0 = 13'h0FFF; #1;
        chk("R6", "bit12 unmasked", 32'(irq), 32'd1);
        mask0 = 13'h1FFF; mask1 = 32'hF7FF_FFFF; #1;
        chk("R6", "s1 bit27 unmasked", 32'(irq), 32'd1);
        mask1 = 32'hFFFF_FFFF; #1;
        chk("R6", "all masked", 32'(irq), 32'd0);

        // R8 event while pending
        mask0 = 13'h0EFF; #1;
        eof_p[0] = 1'b1; tick("R8");
        chk("R8", "subsequent", stat0, 32'h1500);
        chk("R8", "id kept", 32'(src_id), 32'(fid(2)));

        // R11 set beats clear
        eof_p[0] = 1'b1; clr0_we = 1'b1; clr_data = 32'h0500; tick("R11");
        chk("R11", "set wins", stat0, 32'h1500);

        // random phase against the reference
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if (n % 16 == 0) begin
                mask0  = 13'($urandom);
                mask1  = $urandom;
                sof_en = NCH'($urandom);
                eof_en = NCH'($urandom);
                for (int c = 0; c < NCH; c++) fids[c*ID_W +: ID_W] = ID_W'($urandom);
            end
            for (int c = 0; c < NCH; c++) begin
                sof_p[c] = ($urandom % 8) == 0;
                eof_p[c] = ($urandom % 8) == 0;
                brs_p[c] = ($urandom % 10) == 0;
                ber_p[c] = ($urandom % 24) == 0;
                iu_p[c]  = ($urandom % 16) == 0;
            end
            done_p = ($urandom % 12) == 0; acb_p = ($urandom % 12) == 0;
            outrun_p = ($urandom % 12) == 0; rdst_p = ($urandom % 12) == 0;
            cmdi_p = ($urandom % 20) == 0;
            if (($urandom % 5) == 0) en_lvl = ~en_lvl;
            clr0_we = ($urandom % 5) == 0;
            clr1_we = ($urandom % 5) == 0;
            clr_data = $urandom;
            tick("RND R2 R3 R5 R7 R8 R9 R10 R11");
            if (n % 500 == 499) do_reset();
        end

        if (!done_flag) begin
            done_flag = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule